// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This block builds the eight-bit instrument status byte from four live condition inputs: an event-summary bit, a message-available flag (output queue not empty), a fault flag (fault queue not empty) and a power-supply fault flag. It holds a service-request enable mask that software writes and reads back. From the mask and the status bits it derives the master summary bit and keeps it in the status byte.

A separate request-service flag is set each time the master summary bit rises. It drives the service-request output until a bus serial poll takes it. The poll returns a copy of the status byte in which bit 6 carries the request-service flag in place of the master summary bit. The poll clears the flag and leaves the master summary bit alone. The status byte itself has no write path. Queue storage, the event register and the bus transceivers live outside this block.

Top module: `stb_service_unit`

## Requirements
- R1: One clock after the inputs are sampled, `status_o` holds event summary at bit 5 (weight 32), message available at bit 4 (16), fault at bit 3 (8), power-supply fault at bit 2 (4) and the master summary at bit 6 (64).
- R2: Bits 7, 1 and 0 of both `status_o` and `poll_byte_o` always read zero.
- R3: A mask write stores only bits 5, 4 and 3 of `mask_wdata_i` (value AND 0x38), so writing 255 reads back 56. `mask_rdata_o` shows the new value one clock after the write.
- R4: The master summary bit in `status_o` is set exactly when some stored mask bit at position 5, 4 or 3 matches a set status bit in the same position. The mask used is the one held before any write in that same cycle.
- R5: The power-supply fault bit and any written bit 6 of the mask never set the master summary bit.
- R6: When the master summary bit goes from 0 to 1 in `status_o`, the request-service flag is set in the same clock, and `srq_o` is high while the flag is set.
- R7: A cycle with `poll_i` high clears the request-service flag, unless the master summary bit rises in that same clock, in which case the flag is set. A poll never changes the master summary bit.
- R8: On a poll, `poll_byte_o` takes bit 6 from the request-service flag as it was before the poll and bits 5 to 2 from `status_o` as it was before the poll. It holds that value until the next poll.
- R9: After reset the mask, `status_o`, `poll_byte_o` and `srq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_sum_i | input | 1 | Event summary condition |
| msg_avail_i | input | 1 | Output queue not empty |
| fault_i | input | 1 | Fault queue not empty |
| psu_fault_i | input | 1 | Power-supply fault present |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write value |
| mask_rdata_o | output | 8 | Stored enable mask |
| poll_i | input | 1 | Serial poll strobe, one cycle |
| status_o | output | 8 | Status byte with master summary bit |
| poll_byte_o | output | 8 | Byte captured by the last serial poll |
| srq_o | output | 1 | Service request output |

## Verification
The bench aims at a few corner cases. The first is writing all ones to the mask: a design that kept bits 6, 2 or the reserved bits would read back something other than 56. A design that let the power-supply flag drive the summary would raise `srq_o` with a full mask and only that flag set. A poll in the same clock as a summary rising edge must leave the request set; a design that gave priority to the clear would lose that request. The bench also makes sure that polls never move the summary bit and that the poll byte keeps its value between polls.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_W        = 8;
  localparam int POS_MSS      = 6;
  localparam int POS_ESB      = 5;
  localparam int POS_MAV      = 4;
  localparam int POS_FLT      = 3;
  localparam int POS_PSU      = 2;
  // Mask bits that may take part in the summary
  localparam logic [STB_W-1:0] MASK_KEEP =
    (STB_W'(1) << POS_ESB) | (STB_W'(1) << POS_MAV) | (STB_W'(1) << POS_FLT);
endpackage

// File: rtl/stb_mask_reg.sv
module stb_mask_reg
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [STB_W-1:0] wdata_i,
  output logic [STB_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & MASK_KEEP;
  end
endmodule

// File: rtl/stb_assemble.sv
module stb_assemble
  import stb_pkg::*;
(
  input  logic             evt_i,
  input  logic             mav_i,
  input  logic             flt_i,
  input  logic             psu_i,
  input  logic [STB_W-1:0] mask_i,
  output logic [STB_W-1:0] byte_o,
  output logic             mss_o
);
  logic [STB_W-1:0] raw;
  always_comb begin
    raw          = '0;
    raw[POS_ESB] = evt_i;
    raw[POS_MAV] = mav_i;
    raw[POS_FLT] = flt_i;
    raw[POS_PSU] = psu_i;
    mss_o        = |(raw & mask_i & MASK_KEEP);
    byte_o       = raw;
    byte_o[POS_MSS] = mss_o;
  end
endmodule

// File: rtl/stb_rqs_track.sv
module stb_rqs_track
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mss_next_i,
  input  logic             mss_cur_i,
  input  logic             poll_i,
  input  logic [STB_W-1:0] status_i,
  output logic             rqs_o,
  output logic [STB_W-1:0] poll_byte_o
);
  logic rise;
  assign rise = mss_next_i & ~mss_cur_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rqs_o       <= 1'b0;
      poll_byte_o <= '0;
    end else begin
      if (rise)        rqs_o <= 1'b1;
      else if (poll_i) rqs_o <= 1'b0;
      if (poll_i) begin
        poll_byte_o          <= status_i;
        poll_byte_o[POS_MSS] <= rqs_o;
      end
    end
  end
endmodule

// File: rtl/stb_service_unit.sv
module stb_service_unit
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_sum_i,
  input  logic             msg_avail_i,
  input  logic             fault_i,
  input  logic             psu_fault_i,
  input  logic             mask_wr_i,
  input  logic [STB_W-1:0] mask_wdata_i,
  output logic [STB_W-1:0] mask_rdata_o,
  input  logic             poll_i,
  output logic [STB_W-1:0] status_o,
  output logic [STB_W-1:0] poll_byte_o,
  output logic             srq_o
);
  logic [STB_W-1:0] mask_q;
  logic [STB_W-1:0] status_next;
  logic             mss_next;

  stb_mask_reg u_mask (
    .clk(clk), .rst(rst), .wr_i(mask_wr_i),
    .wdata_i(mask_wdata_i), .mask_o(mask_q)
  );

  stb_assemble u_asm (
    .evt_i(evt_sum_i), .mav_i(msg_avail_i), .flt_i(fault_i),
    .psu_i(psu_fault_i), .mask_i(mask_q),
    .byte_o(status_next), .mss_o(mss_next)
  );

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= status_next;
  end

  stb_rqs_track u_rqs (
    .clk(clk), .rst(rst), .mss_next_i(mss_next),
    .mss_cur_i(status_o[POS_MSS]), .poll_i(poll_i),
    .status_i(status_o), .rqs_o(srq_o), .poll_byte_o(poll_byte_o)
  );

  assign mask_rdata_o = mask_q;
endmodule

// File: rtl/stb_service_unit_chk.sv
module stb_service_unit_chk
  import stb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mask_wr_i,
  input logic [STB_W-1:0] mask_wdata_i,
  input logic [STB_W-1:0] mask_rdata_o,
  input logic             poll_i,
  input logic [STB_W-1:0] status_o,
  input logic [STB_W-1:0] poll_byte_o,
  input logic             srq_o
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o[7] == 1'b0) && (status_o[1:0] == 2'b00) &&
    (poll_byte_o[7] == 1'b0) && (poll_byte_o[1:0] == 2'b00));

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    mask_wr_i |=> (mask_rdata_o == ($past(mask_wdata_i) & 8'h38)));

  assert_summary_match_R4: assert property (@(posedge clk) disable iff (rst)
    status_o[POS_MSS] |-> (|(status_o[5:3] & $past(mask_rdata_o[5:3]))));

  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[POS_MSS]) |-> srq_o);

  assert_poll_clears_R7: assert property (@(posedge clk) disable iff (rst)
    poll_i |=> (!srq_o || (status_o[POS_MSS] && !$past(status_o[POS_MSS]))));

  assert_poll_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !poll_i |=> $stable(poll_byte_o));
endmodule

bind stb_service_unit stb_service_unit_chk u_chk (
  .clk(clk), .rst(rst), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
  .mask_rdata_o(mask_rdata_o), .poll_i(poll_i), .status_o(status_o),
  .poll_byte_o(poll_byte_o), .srq_o(srq_o)
);

// File: tb/tb_stb_service_unit.sv
`timescale 1ns/1ps
module tb_stb_service_unit;
  logic clk = 1'b0;
  logic rst;
  logic evt, mav, flt, psu, wr, poll;
  logic [7:0] wdata;
  logic [7:0] mask_rd, status, pbyte;
  logic srq;
  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_mask, m_status, m_pbyte;
  logic       m_rqs;

  always #2 clk = ~clk;

  stb_service_unit dut (
    .clk(clk), .rst(rst), .evt_sum_i(evt), .msg_avail_i(mav),
    .fault_i(flt), .psu_fault_i(psu), .mask_wr_i(wr),
    .mask_wdata_i(wdata), .mask_rdata_o(mask_rd), .poll_i(poll),
    .status_o(status), .poll_byte_o(pbyte), .srq_o(srq)
  );

  function automatic logic [7:0] f_status(logic [7:0] mask, logic e, logic m,
                                           logic f, logic p);
    logic [7:0] b;
    b = {2'b00, e, m, f, p, 2'b00};
    b[6] = |(b & mask & 8'h38);
    return b;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(logic e, logic m, logic f, logic p,
                      logic w, logic [7:0] wd, logic pl);
    logic [7:0] n_status, n_mask, n_pbyte;
    logic n_rqs;
    evt = e; mav = m; flt = f; psu = p; wr = w; wdata = wd; poll = pl;
    n_status = f_status(m_mask, e, m, f, p);
    n_mask   = w ? (wd & 8'h38) : m_mask;
    n_rqs    = (n_status[6] & ~m_status[6]) | (m_rqs & ~pl);
    n_pbyte  = pl ? {1'b0, m_rqs, m_status[5:0]} : m_pbyte;
    @(posedge clk);
    @(negedge clk);
    m_status = n_status; m_mask = n_mask; m_rqs = n_rqs; m_pbyte = n_pbyte;
    chk("R1/R4/R5 status", status, m_status);
    chk("R3 mask", mask_rd, m_mask);
    chk("R6/R7 srq", {7'd0, srq}, {7'd0, m_rqs});
    chk("R8/R2 poll byte", pbyte, m_pbyte);
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    {evt, mav, flt, psu, wr, poll} = '0;
    wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mask = '0; m_status = '0; m_pbyte = '0; m_rqs = 1'b0;
    // R9 reset values
    chk("R9 reset status", status, 8'h00);
    chk("R9 reset mask", mask_rd, 8'h00);
    chk("R9 reset poll byte", pbyte, 8'h00);
    chk("R9 reset srq", {7'd0, srq}, 8'h00);

    // R3: 255 -> 56
    step(0, 0, 0, 0, 1, 8'hFF, 0);
    chk("R3 255 reads 56", mask_rd, 8'd56);
    // R5: psu only, full mask, no summary
    step(0, 0, 0, 1, 0, 8'h00, 0);
    step(0, 0, 0, 1, 0, 8'h00, 0);
    chk("R5 psu no summary", {7'd0, status[6]}, 8'h00);
    // R6: message available raises summary and request
    step(0, 1, 0, 0, 0, 8'h00, 0);
    chk("R6 srq raised", {7'd0, srq}, 8'h01);
    // R7/R8: poll clears request, summary stays
    step(0, 1, 0, 0, 0, 8'h00, 1);
    chk("R7 srq cleared", {7'd0, srq}, 8'h00);
    chk("R7 summary kept", {7'd0, status[6]}, 8'h01);
    chk("R8 poll byte bit6", pbyte, 8'h50);
    // R7: poll coincident with rising edge keeps request
    step(0, 0, 0, 0, 0, 8'h00, 0);
    step(1, 0, 0, 0, 0, 8'h00, 1);
    chk("R7 rise wins over poll", {7'd0, srq}, 8'h01);
    // R5: mask bit 6 written alone has no effect
    step(0, 0, 0, 0, 1, 8'h40, 0);
    chk("R5 bit6 dropped", mask_rd, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3], (r[7:4] == 4'd0), r[15:8], (r[19:17] == 3'd0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule